// File: doc/BRIEF.md
# Configurable Interrupt Request Pin Driver

This block converts a single-cycle internal interrupt event into the signal on an external interrupt request pin. A set of configuration inputs decides how that pin behaves. Polarity can be active-high or active-low. Signalling can be a level that holds until software clears it, or a pulse of programmable length. Drive can be push-pull, or open-drain through a separate output-enable.

The pin driver sits outside the block and combines `pin_o` with `pin_oe_o`. The pulse counter runs on `clk`, which is whichever clock the host interface mode selects. The configuration inputs are expected to stay unchanged while the request is asserted. A 16-bit width field sets the pulse length. Field values of 2 and above give the value plus two cycles. Values 0 and 1 both give the minimum of 3 cycles, so the usable range is 3 to 65,537 cycles.

Top module: `irq_pin_drv`

## Requirements
- R1: While `rst_n` is low, and after it rises with no event, the request is deasserted. In push-pull mode `pin_oe_o`=1 and `pin_o` shows the inactive level (1 when `cfg_act_high_i`=0, 0 when it is 1). In open-drain mode `pin_oe_o`=0.
- R2: An event (`evt_i`=1 at a rising edge) asserts the request from that edge on, in both level and pulse mode.
- R3: With `cfg_open_drain_i`=0, `pin_oe_o` is always 1. `pin_o` equals the asserted state when `cfg_act_high_i`=1 and its inverse when `cfg_act_high_i`=0.
- R4: With `cfg_open_drain_i`=1, `pin_oe_o` is 1 exactly while the request is asserted. `pin_o` is 0 for active-low and 1 for active-high.
- R5: In level mode (`cfg_pulse_i`=0), the request stays asserted until `clr_i`=1 at a rising edge with no event. It is deasserted from that edge on.
- R6: In level mode, an event and a clear at the same edge leave the request asserted.
- R7: In pulse mode (`cfg_pulse_i`=1), the request stays asserted for exactly max(W,1)+2 cycles after the event edge, where W is `cfg_width_i`. It then deasserts by itself.
- R8: In pulse mode, an event that arrives during an active pulse restarts the full width from the new event's edge.
- R9: In pulse mode, `clr_i` has no effect on the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that also times the pulse width |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Interrupt event, one cycle per event |
| clr_i | input | 1 | Clear strobe for level mode |
| cfg_act_high_i | input | 1 | 1: asserted level is high; 0: asserted level is low |
| cfg_pulse_i | input | 1 | 1: pulse signalling; 0: level signalling |
| cfg_open_drain_i | input | 1 | 1: open-drain drive; 0: push-pull drive |
| cfg_width_i | input | WIDTH_W | Pulse width field (max(W,1)+2 cycles) |
| pin_o | output | 1 | Pin data |
| pin_oe_o | output | 1 | Pin output-enable |

## Verification
The bench targets the pulse-width boundaries: field values 0, 1 and 2, and the all-ones field that gives 65,537 cycles. A counter that is off by one, or that wraps, shortens or lengthens the pulse by a cycle and is caught on the exact edge. Restarts in mid-pulse are exercised; a design that ignores them ends the pulse early. The bench also drives an event and a clear in the same cycle; a design that lets the clear win drops the request. Clears are sent in pulse mode, where a design that honours them cuts the pulse short. All four combinations of polarity and drive are applied, so an inverted data level or an enable that is left on during open-drain idle shows up as a mismatch on the pin.

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_i,
  input  logic               clr_i,
  input  logic               cfg_act_high_i,
  input  logic               cfg_pulse_i,
  input  logic               cfg_open_drain_i,
  input  logic [WIDTH_W-1:0] cfg_width_i,
  output logic               pin_o,
  output logic               pin_oe_o
);
  localparam int CNT_W = WIDTH_W + 1;

  logic             act;
  logic [CNT_W-1:0] cnt;

  wire [CNT_W-1:0] width_eff = (cfg_width_i == '0) ? CNT_W'(1) : CNT_W'(cfg_width_i);
  wire [CNT_W-1:0] load_val  = width_eff + CNT_W'(1);
  wire             cnt_zero  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (evt_i) begin
      act <= 1'b1;
      cnt <= load_val;
    end else if (cfg_pulse_i) begin
      if (act) begin
        if (cnt_zero) act <= 1'b0;
        else          cnt <= cnt - CNT_W'(1);
      end
    end else if (clr_i) begin
      act <= 1'b0;
    end
  end

  assign pin_o    = cfg_open_drain_i ? cfg_act_high_i : (act ~^ cfg_act_high_i);
  assign pin_oe_o = cfg_open_drain_i ? act : 1'b1;

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> act);

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pulse_i && act && !evt_i && !clr_i) |=> act);

  // R5
  level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pulse_i && clr_i && !evt_i) |=> !act);

  // R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pulse_i && act && cnt_zero && !evt_i) |=> !act);

  // R7
  pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pulse_i && act && !cnt_zero) |=> act);

  // R9
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pulse_i && !act && !evt_i) |=> !act);

  // R4
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open_drain_i && !act) |-> !pin_oe_o);
endmodule

// File: tb/irq_pin_drv_tb_top.sv
`timescale 1ns/1ps
module irq_pin_drv_tb_top;
  localparam int WIDTH_W = 16;

  logic clk = 0, rst_n = 0, evt = 0, clr = 0;
  logic ah = 0, pulse = 0, od = 0;
  logic [WIDTH_W-1:0] width = '0;
  logic pin, oe;

  int vec = 0, bad = 0, cyc = 0;
  int exp_end = 0;
  logic exp_act = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_pin_drv #(.WIDTH_W(WIDTH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr),
    .cfg_act_high_i(ah), .cfg_pulse_i(pulse), .cfg_open_drain_i(od),
    .cfg_width_i(width), .pin_o(pin), .pin_oe_o(oe));

  function automatic int eff_len(input logic [WIDTH_W-1:0] w);
    return ((w < 1) ? 1 : int'(w)) + 2;
  endfunction

  function automatic logic want_pin(input logic a);
    if (od) return ah;
    return ah ? a : !a;
  endfunction

  function automatic logic want_oe(input logic a);
    return od ? a : 1'b1;
  endfunction

  task automatic check(input string tag);
    vec++;
    if (pin !== want_pin(exp_act) || oe !== want_oe(exp_act)) begin
      bad++;
      $display("FAIL %s cyc=%0d pin/oe actual=%b%b expected=%b%b",
               tag, cyc, pin, oe, want_pin(exp_act), want_oe(exp_act));
    end
  endtask

  task automatic step(input logic e, input logic c, input string tag);
    evt = e; clr = c;
    @(posedge clk);
    cyc++;
    if (e) begin
      exp_act = 1; exp_end = cyc + eff_len(width);
    end else if (pulse) begin
      if (exp_act && cyc >= exp_end) exp_act = 0;
    end else if (c) begin
      exp_act = 0;
    end
    @(negedge clk);
    evt = 0; clr = 0;
    check(tag);
  endtask

  task automatic drain(input string tag);
    if (pulse) begin
      while (exp_act) step(0, 0, tag);
    end else begin
      step(0, 1, tag);
    end
  endtask

  task automatic set_cfg(input logic p, input logic o, input logic h, input int w);
    pulse = p; od = o; ah = h; width = WIDTH_W'(w);
    @(negedge clk);
    check("R1 idle");
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state, several configurations
    set_cfg(0, 0, 0, 0); check("R1");
    set_cfg(0, 0, 1, 0); check("R1");
    set_cfg(0, 1, 0, 0); check("R1");
    rst_n = 1;
    repeat (2) step(0, 0, "R1");

    // R2 R5 R6 level mode, push-pull active-low
    set_cfg(0, 0, 0, 0);
    step(1, 0, "R2");
    repeat (4) step(0, 0, "R5 hold");
    step(1, 1, "R6 evt+clr");
    step(0, 0, "R6 held");
    step(0, 1, "R5 clear");
    step(0, 0, "R5 idle");

    // R4 open-drain both polarities
    set_cfg(0, 1, 0, 0);
    step(1, 0, "R4 od low"); step(0, 1, "R4 od low release");
    set_cfg(0, 1, 1, 0);
    step(1, 0, "R4 od high"); step(0, 1, "R4 od high release");

    // R7 boundary widths 0,1,2
    for (int w = 0; w < 3; w++) begin
      set_cfg(1, 0, 1, w);
      step(1, 0, "R7 start");
      drain("R7 width");
      step(0, 0, "R7 after");
    end

    // R8 restart and R9 clear ignored
    set_cfg(1, 0, 0, 4);
    step(1, 0, "R8");
    step(0, 1, "R9 clr in pulse");
    step(0, 0, "R8");
    step(1, 0, "R8 restart");
    drain("R8 restart len");
    step(0, 1, "R9 clr idle");

    // R7 maximum width
    set_cfg(1, 1, 0, 65535);
    step(1, 0, "R7 max");
    drain("R7 max len");
    step(0, 0, "R7 max after");

    // constrained random segments
    for (int s = 0; s < 60; s++) begin
      set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(0, 6));
      for (int k = 0; k < 40; k++) begin
        step(1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 3) == 0),
             pulse ? (od ? "R4 R7 R8 R9" : "R3 R7 R8 R9")
                   : (od ? "R4 R5 R6" : "R3 R5 R6"));
      end
      drain("R3 R4 drain");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule